// File: doc/BRIEF.md
# Multi-master SCL clock synchronizer

This block produces the serial clock of one master on a two-wire bus whose clock line is open-drain and shared with other masters. The line reads low whenever any device pulls it low. The block counts its own low and high phases in system-clock cycles, and it follows the shared line rather than running free. A falling edge caused by any device starts the block's low count. The block keeps pulling the line low until that count expires. It then lets go and waits, without counting, until the line is really high. Only then does it count its high phase. If another master pulls the line low first, the block drops its high count and begins a new low phase.

The result is that the bus clock's low time is set by the slowest master and its high time by the fastest. The sampled line passes through a two-stage synchronizer. The block reports each synchronized rising and falling edge as a one-cycle strobe, whether or not it is enabled. When disabled, the block never pulls the line low.

Top module: `scl_clock_sync`

## Requirements
- R1: During and just after reset, `scl_drive_low`, `high_wait`, `scl_rise` and `scl_fall` are all 0.
- R2: Each change of the line produces exactly one one-cycle strobe: `scl_rise` for low-to-high and `scl_fall` for high-to-low. The strobe is visible in the cycle that follows the second rising clock edge after the change, and the two strobes are never high together.
- R3: Each low phase holds `scl_drive_low` at 1 for exactly `low_count` cycles. A `low_count` of 0 behaves as 1.
- R4: When the low count expires, `scl_drive_low` returns to 0 and `high_wait` is 1. `high_wait` stays 1 until the synchronized line is seen high. Alone on the bus this lasts 3 cycles. When another master holds the line low for N cycles from the start of the block's low phase, it lasts N − `low_count` cycles before the line rises.
- R5: The high count starts only from the synchronized rise. If nobody pulls the line low, `scl_drive_low` returns to 1 on the (`high_count` + 3)-th clock edge after the line goes high. This is 3 cycles of synchronization and edge detection plus `high_count` cycles; a `high_count` of 0 behaves as 1.
- R6: If the line falls while the high count runs, the block drops that count. It asserts `scl_drive_low` on the third clock edge after the fall and starts a full `low_count` low phase.
- R7: While `enable` is 0 the block never drives the line, but R2 still holds. `scl_drive_low` goes to 0 on the first clock edge after `enable` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1: act as a clock-generating master; 0: observe only |
| low_count | input | CNT_W | Low phase length in cycles (0 treated as 1) |
| high_count | input | CNT_W | High phase length in cycles (0 treated as 1) |
| scl_in | input | 1 | Sampled level of the shared clock line |
| scl_drive_low | output | 1 | 1: pull the shared line low |
| high_wait | output | 1 | Low count expired, waiting for the line to go high |
| scl_rise | output | 1 | One-cycle strobe on a synchronized rising edge |
| scl_fall | output | 1 | One-cycle strobe on a synchronized falling edge |

## Verification
The assertion on the counter's range assumes that `low_count` and `high_count` stay constant while the block is enabled. The bench changes them only while `enable` is 0, when no count runs. The edge assertions assume the line level is held for at least two clock cycles between changes. The bench's second master therefore drives the line only on falling clock edges and holds each level for several cycles. It drives the line only through the wired-AND model, so the block never sees a high level while it is pulling the line low.

// File: rtl/scl_sync_pkg.sv
// Package: shared phase encoding of the SCL clock synchronizer.
package scl_sync_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // not generating clock
        PH_LOW  = 2'd1,  // counting own low time, pulling line low
        PH_WAIT = 2'd2,  // own low time done, line still low
        PH_HIGH = 2'd3   // counting own high time, line released
    } phase_t;
endpackage

// File: rtl/scl_line_sync.sv
// Module: scl_line_sync
// Brings the asynchronous line level into the clock domain with STAGES flops
// and produces one-cycle rise/fall strobes from the synchronized level.
// Assumes the idle line is high; STAGES is at least 2.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    output logic scl_level,
    output logic scl_rise,
    output logic scl_fall
);
    logic [STAGES-1:0] pipe;
    logic              level_q;

    // Shift the raw line level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], scl_in};
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b1;
        else        level_q <= pipe[STAGES-1];
    end

    assign scl_level = pipe[STAGES-1];
    assign scl_rise  = scl_level & ~level_q;
    assign scl_fall  = ~scl_level & level_q;

    // R2: a strobe lasts one cycle only.
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise);
    assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> !scl_fall);
endmodule

// File: rtl/scl_period_counter.sv
// Module: scl_period_counter
// Counts cycles of the current phase. 'done' is high in the last cycle of a
// phase of 'limit' cycles (limit 0 acts as 1). Assumes limit is stable while run.
module scl_period_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_plus;

    assign cnt_plus = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign done     = run && (cnt_plus >= {1'b0, limit});

    // Restart on a phase change, otherwise advance until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (run && !done) cnt <= cnt + 1'b1;
    end

    // R3: the count never passes the programmed length.
    assert_cnt_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/scl_phase_ctrl.sv
// Module: scl_phase_ctrl
// Phase sequencer: low count -> wait for line high -> high count -> low.
// A line fall during the high count restarts the low phase. Disabled: idle.
// Assumes edge strobes come from the synchronized line level.
module scl_phase_ctrl
    import scl_sync_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   scl_level,
    input  logic   scl_rise,
    input  logic   scl_fall,
    input  logic   cnt_done,
    output phase_t phase,
    output logic   cnt_clr
);
    phase_t phase_nx;

    // Choose the next phase from the line events and the count.
    always_comb begin
        phase_nx = phase;
        if (!enable) begin
            phase_nx = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: phase_nx = scl_level ? PH_HIGH : PH_LOW;
                PH_LOW:  if (cnt_done) phase_nx = PH_WAIT;
                PH_WAIT: if (scl_rise) phase_nx = PH_HIGH;
                PH_HIGH: if (scl_fall || cnt_done) phase_nx = PH_LOW;
                default: phase_nx = PH_IDLE;
            endcase
        end
    end

    assign cnt_clr = (phase_nx != phase);

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // R6: a line fall during the high count starts a low phase.
    assert_cut_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_HIGH && scl_fall) |=> (phase == PH_LOW));
    // R4: the wait phase is entered only from an expired low phase.
    assert_wait_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && $past(phase) != PH_WAIT) |-> ($past(phase) == PH_LOW));
    // R5: the high count begins only on a synchronized rise.
    assert_high_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH && $past(phase) == PH_WAIT) |-> $past(scl_rise));
endmodule

// File: rtl/scl_clock_sync.sv
// Module: scl_clock_sync (top)
// SCL generator for one master on a shared wired-AND clock line. Low time is
// stretched by slower masters, high time cut short by faster ones.
// Assumes scl_in is the raw line level and period inputs are stable while enabled.
module scl_clock_sync
    import scl_sync_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             high_wait,
    output logic             scl_rise,
    output logic             scl_fall
);
    logic             scl_level;
    logic             cnt_done;
    logic             cnt_clr;
    logic             cnt_run;
    logic [CNT_W-1:0] cnt_limit;
    phase_t           phase;

    scl_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .scl_level (scl_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    // Pick the length of the phase being counted.
    always_comb begin
        cnt_limit = (phase == PH_HIGH) ? high_count : low_count;
        cnt_run   = (phase == PH_LOW) || (phase == PH_HIGH);
    end

    scl_period_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .limit (cnt_limit),
        .done  (cnt_done)
    );

    scl_phase_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_level (scl_level),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .cnt_done  (cnt_done),
        .phase     (phase),
        .cnt_clr   (cnt_clr)
    );

    assign scl_drive_low = (phase == PH_LOW);
    assign high_wait     = (phase == PH_WAIT);

    // R7: no drive in the cycle after enable is low.
    assert_no_drive_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low);
    // R4: waiting starts right after the block let go of the line.
    assert_wait_follows_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(high_wait) |-> $past(scl_drive_low));
    // R2: edge strobes are mutually exclusive.
    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall));
endmodule

// File: tb/scl_clock_sync_tb.sv
// Bench: directed scenarios for scl_clock_sync with a second master modelled
// on the wired-AND line. Inputs change on falling clock edges; outputs are
// sampled on falling clock edges.
module scl_clock_sync_tb_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] low_count = 8'd5;
    logic [CNT_W-1:0] high_count = 8'd4;
    logic             other_drv = 1'b0;
    logic             scl_line;
    logic             scl_drive_low, high_wait, scl_rise, scl_fall;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign scl_line = ~(scl_drive_low | other_drv);

    scl_clock_sync #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .low_count     (low_count),
        .high_count    (high_count),
        .scl_in        (scl_line),
        .scl_drive_low (scl_drive_low),
        .high_wait     (high_wait),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait at falling edges until the drive output equals 'lvl'; bounded.
    task automatic wait_drive(input logic lvl, input string req);
        int n = 0;
        while (scl_drive_low !== lvl && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check({req, " drive reached"}, int'(scl_drive_low === lvl), 1);
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable    = 1'b0;
        other_drv = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 drive in reset", int'(scl_drive_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 drive", int'(scl_drive_low), 0);
        check("R1 high_wait", int'(high_wait), 0);
        check("R1 rise", int'(scl_rise), 0);
        check("R1 fall", int'(scl_fall), 0);
    endtask

    // Alone on the bus: low L cycles, wait 3 cycles, resume H+3 after release.
    task automatic t_solo(input int l_set, input int h_set, input int l_exp, input int h_exp);
        int nd = 0;
        int nz = 0;
        int nw = 0;
        low_count  = l_set[CNT_W-1:0];
        high_count = h_set[CNT_W-1:0];
        @(negedge clk);
        enable = 1'b1;
        wait_drive(1'b1, "R3 solo start");
        while (scl_drive_low && nd < 2000) begin nd++; @(negedge clk); end
        check("R3 low phase length", nd, l_exp);
        while (!scl_drive_low && nz < 2000) begin
            if (high_wait) nw++;
            nz++;
            @(negedge clk);
        end
        check("R4 solo wait length", nw, 3);
        check("R5 solo release-to-drive", nz, h_exp + 3);
        go_idle();
    endtask

    // Slower master holds low for 'lo' cycles: low stretched, then H+3.
    task automatic t_stretch(input int l_set, input int h_set, input int lo);
        int nd = 0;
        int nw = 0;
        int n  = 0;
        low_count  = l_set[CNT_W-1:0];
        high_count = h_set[CNT_W-1:0];
        @(negedge clk);
        enable = 1'b1;
        wait_drive(1'b1, "R4 stretch start");
        other_drv = 1'b1;
        for (int i = 0; i < lo; i++) begin
            if (scl_drive_low) nd++;
            if (high_wait) nw++;
            @(negedge clk);
        end
        check("R3 stretched own drive", nd, l_set);
        check("R4 wait during stretch", nw, lo - l_set);
        other_drv = 1'b0;
        do begin @(negedge clk); n++; end while (!scl_drive_low && n < 2000);
        check("R5 release-to-drive after stretch", n, h_set + 3);
        go_idle();
    endtask

    // Faster master pulls low 'k' cycles into the high count.
    task automatic t_cut(input int l_set, input int h_set, input int k);
        int n  = 0;
        int nd = 0;
        low_count  = l_set[CNT_W-1:0];
        high_count = h_set[CNT_W-1:0];
        @(negedge clk);
        enable = 1'b1;
        wait_drive(1'b1, "R6 cut start");
        wait_drive(1'b0, "R6 cut release");
        while (high_wait || n < 1) begin @(negedge clk); n++; end
        repeat (k) @(negedge clk);
        other_drv = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!scl_drive_low && n < 2000);
        check("R6 drive after foreign fall", n, 3);
        other_drv = 1'b0;
        while (scl_drive_low && nd < 2000) begin nd++; @(negedge clk); end
        check("R6 full low phase after cut", nd, l_set);
        go_idle();
    endtask

    // Disabled: line toggled by other master, no drive, strobes reported.
    task automatic t_disabled();
        int drv = 0;
        int nr  = 0;
        int nf  = 0;
        int lat = -1;
        enable = 1'b0;
        for (int p = 0; p < 2; p++) begin
            other_drv = 1'b1;
            for (int i = 1; i <= 6; i++) begin
                @(negedge clk);
                if (scl_drive_low) drv++;
                if (scl_rise) nr++;
                if (scl_fall) begin nf++; if (p == 0 && lat < 0) lat = i; end
            end
            other_drv = 1'b0;
            for (int i = 1; i <= 6; i++) begin
                @(negedge clk);
                if (scl_drive_low) drv++;
                if (scl_rise) nr++;
                if (scl_fall) nf++;
            end
        end
        check("R7 no drive when disabled", drv, 0);
        check("R2 fall strobes", nf, 2);
        check("R2 rise strobes", nr, 2);
        check("R2 fall strobe latency", lat, 2);
    endtask

    // Dropping enable mid low phase releases on the next edge.
    task automatic t_disable_mid();
        low_count  = 8'd10;
        high_count = 8'd4;
        @(negedge clk);
        enable = 1'b1;
        wait_drive(1'b1, "R7 mid start");
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R7 drive dropped after disable", int'(scl_drive_low), 0);
        go_idle();
    endtask

    initial begin
        #(20 * 150000);
        n_fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        go_idle();
        t_solo(5, 4, 5, 4);
        t_solo(0, 0, 1, 1);
        t_solo(2, 7, 2, 7);
        t_stretch(3, 6, 12);
        t_cut(4, 20, 5);
        t_disabled();
        t_disable_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule